// File: doc/BRIEF.md
# Half-duplex buffered SPI master

This block is a register-mapped SPI master that runs one half-duplex transaction per start command. Software loads a 32-bit command word, fills a 32-byte data buffer, programs three bit counts and a clock divisor, and then sets the start bit. The engine shifts out the command bits first and then the extra transmit bits taken from the buffer. After that it clocks in the programmed number of receive bits and writes them back into the same buffer, which software reads once the busy flag drops.

The register port is a plain 32-bit word-indexed interface. Writes are taken on the clock edge and reads are combinational. Only SPI mode 0 is provided: SCK idles low, MOSI changes when SCK falls, and MISO is sampled when SCK rises. Two chip selects are controlled by software and do not depend on the engine.

Register word indices (byte offset = 4 x index): 0 control/status, 1 command word, 2..9 data buffer words 0..7, 10 configuration, 11 bit counts, 14 chip-select mask.

Top module: `hd_spi_master`

## Requirements
- R1: After reset the busy flag reads 0, SCK and MOSI are low, every chip-select pin is high, and the command, buffer, configuration, count and select registers all read 0.
- R2: Configuration bits 27:16 hold the divisor d minus 2, so d ranges from 2 to 4097. Each SPI bit lasts d system clocks. SCK is low for the first d - floor(d/2) clocks of a bit and high for the last floor(d/2). SCK is low whenever no transaction runs.
- R3: Writing the control register with bit 8 set while idle starts a transaction, and control bit 16 reads the busy flag. Busy stays high for exactly d*N+1 clocks after the write edge, where N is the total clamped bit count, so a transaction with all counts zero is busy for one clock and issues no SCK pulse.
- R4: The count register holds the command bit count in bits 31:24, the receive bit count in bits 23:12 and the extra transmit bit count in bits 11:0. A command count above 32 acts as 32, and a transmit or receive count above 256 acts as 256.
- R5: Bits go out in this order: the command bits, then the buffer transmit bits, then the receive bits. MOSI is held low during the receive bits.
- R6: The command word is sent big-endian: bits 31:24 form the first byte, and a command count below 32 sends only the leading bits of that byte stream.
- R7: Transmit byte j of the buffer stream is bits 8*(j mod 4)+7 down to 8*(j mod 4) of buffer word j/4.
- R8: Receive byte i is stored into bits 8*(i mod 4)+7 down to 8*(i mod 4) of buffer word i/4. In a partial last byte, the bits that are not received keep their old value.
- R9: Configuration bit 3 set sends and receives each byte starting with its bit 0. Clear, each byte starts with its bit 7. The setting applies to every phase.
- R10: MOSI changes only together with an SCK fall (and at the start), and stays steady while SCK is high. MISO is sampled on the clock edge at which SCK rises.
- R11: Bit k of the select register (bits NCS-1:0) drives chip-select pin k low when set. The register can be written at any time, including while busy.
- R12: While busy, a start request is ignored, and writes to the command, buffer, configuration and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
A start write taken on clock edge E raises busy on that edge, and busy falls on edge E + d*N + 1. The bench therefore drives every input on the falling clock edge and reads busy combinationally 1 ns later. It counts the busy samples, which must total exactly d*N+1. Serial data is judged against the SCK pin itself. A bench-side slave records MOSI on each SCK rise and presents the next MISO bit on each SCK fall, which is the timing the engine samples against. Buffer contents are read back only after busy has been seen low, and are compared with a bench model updated bit by bit from the receive pattern.

// File: rtl/hd_spi_master.sv
module hd_spi_master #(
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     reg_addr,
  input  logic           reg_we,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);
  localparam int DIV_W     = 12;
  localparam int BUF_BYTES = 32;
  localparam int BUF_BITS  = BUF_BYTES * 8;
  localparam int CMD_MAX   = 32;
  localparam int CW        = $clog2(CMD_MAX + 1);
  localparam int XW        = $clog2(BUF_BITS + 1);
  localparam int GW        = $clog2(CMD_MAX + 2 * BUF_BITS + 1);
  localparam int TW        = DIV_W + 1;

  localparam logic [3:0] A_CTRL = 4'd0, A_CMD = 4'd1, A_CFG = 4'd10,
                         A_CNT = 4'd11, A_SEL = 4'd14;

  logic [31:0]       cmd_q;
  logic [BUF_BITS-1:0] buf_q;
  logic [DIV_W-1:0]  div_q;
  logic              lsb_q;
  logic [31:0]       cnt_q;
  logic [NCS-1:0]    sel_q;
  logic              busy_q;
  logic              sck_q;
  logic [TW-1:0]     tick_q;
  logic [GW-1:0]     pos_q;

  function automatic logic [2:0] bsel(input logic [2:0] b, input logic lsb);
    return lsb ? b : ~b;
  endfunction

  logic [TW-1:0] dv, lo_last, bit_last;
  assign dv       = TW'(div_q) + TW'(2);
  assign lo_last  = dv - (dv >> 1) - TW'(1);
  assign bit_last = dv - TW'(1);

  logic [CW-1:0] cmd_n;
  logic [XW-1:0] tx_n, rx_n;
  logic [GW-1:0] tx_end, total;
  assign cmd_n  = (cnt_q[31:24] > 8'd32)  ? CW'(CMD_MAX)  : cnt_q[24 +: CW];
  assign rx_n   = (cnt_q[23:12] > 12'd256) ? XW'(BUF_BITS) : cnt_q[12 +: XW];
  assign tx_n   = (cnt_q[11:0]  > 12'd256) ? XW'(BUF_BITS) : cnt_q[0 +: XW];
  assign tx_end = GW'(cmd_n) + GW'(tx_n);
  assign total  = tx_end + GW'(rx_n);

  logic in_cmd, in_tx, in_rx;
  assign in_cmd = pos_q < GW'(cmd_n);
  assign in_tx  = !in_cmd && (pos_q < tx_end);
  assign in_rx  = !in_cmd && !in_tx && (pos_q < total);

  logic [7:0] tx_idx, rx_idx;
  assign tx_idx = 8'(pos_q - GW'(cmd_n));
  assign rx_idx = 8'(pos_q - tx_end);

  logic cmd_bit, tx_bit;
  assign cmd_bit = cmd_q[{~pos_q[4:3], bsel(pos_q[2:0], lsb_q)}];
  assign tx_bit  = buf_q[{tx_idx[7:3], bsel(tx_idx[2:0], lsb_q)}];

  assign spi_mosi = busy_q && (in_cmd ? cmd_bit : (in_tx && tx_bit));
  assign spi_sck  = sck_q;
  assign spi_cs_n = ~sel_q;

  logic [2:0] wsel;
  assign wsel = 3'(reg_addr - 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      buf_q  <= '0;
      div_q  <= '0;
      lsb_q  <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      tick_q <= '0;
      pos_q  <= '0;
    end else begin
      if (reg_we && reg_addr == A_SEL)
        sel_q <= reg_wdata[NCS-1:0];
      if (reg_we && !busy_q) begin
        case (reg_addr)
          A_CTRL: if (reg_wdata[8]) begin
            busy_q <= 1'b1;
            pos_q  <= '0;
            tick_q <= '0;
            sck_q  <= 1'b0;
          end
          A_CMD: cmd_q <= reg_wdata;
          4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
            buf_q[{wsel, 5'd0} +: 32] <= reg_wdata;
          A_CFG: begin
            div_q <= reg_wdata[27:16];
            lsb_q <= reg_wdata[3];
          end
          A_CNT: cnt_q <= reg_wdata;
          default: ;
        endcase
      end
      if (busy_q) begin
        if (pos_q == total) begin
          busy_q <= 1'b0;
        end else begin
          if (tick_q == lo_last) begin
            sck_q <= 1'b1;
            if (in_rx)
              buf_q[{rx_idx[7:3], bsel(rx_idx[2:0], lsb_q)}] <= spi_miso;
          end
          if (tick_q == bit_last) begin
            sck_q  <= 1'b0;
            tick_q <= '0;
            pos_q  <= pos_q + GW'(1);
          end else begin
            tick_q <= tick_q + TW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[16] = busy_q;
      A_CMD:  reg_rdata = cmd_q;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
        reg_rdata = buf_q[{wsel, 5'd0} +: 32];
      A_CFG: begin
        reg_rdata[27:16] = div_q;
        reg_rdata[3]     = lsb_q;
      end
      A_CNT:  reg_rdata = cnt_q;
      A_SEL:  reg_rdata[NCS-1:0] = sel_q;
      default: ;
    endcase
  end

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !spi_sck);

  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pos_q != total) |=> busy_q);

  p_mosi_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && spi_sck) |-> $stable(spi_mosi));

  p_advance_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && pos_q != $past(pos_q)) |-> $fell(spi_sck));

  p_cmd_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we && reg_addr == A_CMD) |=> $stable(cmd_q));

  p_sel_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SEL) |=> (spi_cs_n == ~$past(reg_wdata[NCS-1:0])));

endmodule

// File: tb/hd_spi_master_tb.sv
`timescale 1ns/1ps
module hd_spi_master_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi;
  logic        miso = 0;
  logic [1:0]  cs_n;

  int total = 0, bad = 0;

  bit mpat [0:599];
  bit cap  [0:599];
  int rc = 0;
  logic [255:0] bmodel;

  hd_spi_master #(.NCS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n));

  always #5 clk = ~clk;

  always @(posedge sck) begin
    if (rc < 600) cap[rc] = mosi;
    rc = rc + 1;
  end
  always @(negedge sck) begin
    if (rc < 600) miso = mpat[rc];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    addr = 4'(a); wdata = v; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  function automatic logic [31:0] mix(input int a, input int b);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B1 ^ 32'(b) * 32'h85EBCA6B;
    return x ^ (x >> 13) ^ 32'(a + b);
  endfunction

  task automatic run_txn(input int d, input bit lsb, input int c, input int t,
                         input int r, input int seed, input bit intf);
    logic [31:0] cmd, v;
    int cc, tc, rcnt, tot, bcnt, shi, mc, mt, mr, pos, b;
    logic busy, e;
    string id;
    id = $sformatf("d=%0d lsb=%0d c=%0d t=%0d r=%0d", d, lsb, c, t, r);
    for (int w = 0; w < 8; w++) begin
      v = mix(seed, w);
      bmodel[w*32 +: 32] = v;
      wr(2 + w, v);
    end
    cmd = mix(seed, 99);
    wr(1, cmd);
    wr(10, (32'(d - 2) << 16) | (32'(lsb) << 3));
    wr(11, (32'(c) << 24) | (32'(r) << 12) | 32'(t));
    cc = (c > 32) ? 32 : c;
    tc = (t > 256) ? 256 : t;
    rcnt = (r > 256) ? 256 : r;
    tot = cc + tc + rcnt;
    for (int k = 0; k < 600; k++) mpat[k] = mix(seed + 7, k)[5];
    for (int k = 0; k < 600; k++) cap[k] = 0;
    rc = 0;
    miso = mpat[0];
    wr(0, 32'h100);
    bcnt = 0; shi = 0;
    forever begin
      if (intf && (bcnt == 3 || bcnt == 4)) begin
        addr = (bcnt == 3) ? 4'd0 : 4'd1;
        wdata = (bcnt == 3) ? 32'h100 : ~cmd;
        we = 1;
        #1 busy = 1;
      end else begin
        we = 0; addr = 4'd0;
        #1 busy = rdata[16];
      end
      if (!busy || bcnt > 100000) break;
      bcnt++;
      shi += int'(sck);
      @(negedge clk);
    end
    we = 0;
    chk($sformatf("R3 busy cycles %s", id), 32'(bcnt), 32'(d * tot + 1));
    chk($sformatf("R2 sck pulses %s", id), 32'(rc), 32'(tot));
    chk($sformatf("R2 sck high cycles %s", id), 32'(shi), 32'((d / 2) * tot));
    mc = 0; mt = 0; mr = 0;
    for (int k = 0; k < tot && k < 600; k++) begin
      b = lsb ? (k % 8) : (7 - k % 8);
      if (k < cc) begin
        e = cmd[24 - 8 * (k / 8) + b];
        if (cap[k] != e) mc++;
      end else if (k < cc + tc) begin
        pos = k - cc;
        e = bmodel[8 * (pos / 8) + (lsb ? pos % 8 : 7 - pos % 8)];
        if (cap[k] != e) mt++;
      end else if (cap[k] != 0) mr++;
    end
    chk($sformatf("R6/R9 cmd bit mismatches %s", id), 32'(mc), 0);
    chk($sformatf("R7/R9 tx bit mismatches %s", id), 32'(mt), 0);
    chk($sformatf("R5 mosi high in rx %s", id), 32'(mr), 0);
    for (int i = 0; i < rcnt; i++)
      bmodel[8 * (i / 8) + (lsb ? i % 8 : 7 - i % 8)] = mpat[cc + tc + i];
    for (int w = 0; w < 8; w++) begin
      rd(2 + w, v);
      chk($sformatf("R8 buffer word %0d %s", w, id), v, bmodel[w*32 +: 32]);
    end
    rd(1, v);
    chk($sformatf("R12 cmd kept %s", id), v, cmd);
    rd(11, v);
    chk($sformatf("R4 count readback %s", id), v, (32'(c) << 24) | (32'(r) << 12) | 32'(t));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v);  chk("R1 ctrl after reset", v, 0);
    rd(1, v);  chk("R1 cmd after reset", v, 0);
    rd(5, v);  chk("R1 buffer after reset", v, 0);
    rd(10, v); chk("R1 cfg after reset", v, 0);
    rd(11, v); chk("R1 counts after reset", v, 0);
    rd(14, v); chk("R1 select after reset", v, 0);
    chk("R1 pins after reset", {29'd0, sck, mosi, 1'b0} | 32'(cs_n), 32'h3);

    for (int s = 0; s < 4; s++) begin
      wr(14, 32'(s));
      #1 chk("R11 chip selects", 32'(cs_n), 32'(~s & 3));
    end
    wr(14, 1);

    for (int d = 2; d <= 9; d++) run_txn(d, 0, 8, 8, 8, d, 0);
    run_txn(4097, 0, 1, 0, 0, 11, 0);

    for (int c = 0; c <= 32; c++)
      for (int l = 0; l < 2; l++) run_txn(2, l[0], c, 0, 0, 100 + c, 0);

    foreach (v[i]) if (i < 9) begin
      int tl [9] = '{1, 7, 8, 9, 31, 32, 100, 255, 256};
      run_txn(2, 0, 4, tl[i], 0, 200 + i, 0);
      run_txn(3, 1, 4, tl[i], 0, 300 + i, 0);
    end

    foreach (v[i]) if (i < 7) begin
      int rl [7] = '{1, 3, 8, 13, 64, 255, 256};
      run_txn(2, 0, 8, 0, rl[i], 400 + i, 0);
      run_txn(2, 1, 8, 0, rl[i], 500 + i, 0);
    end

    run_txn(2, 0, 6, 13, 21, 600, 0);
    run_txn(5, 1, 19, 3, 5, 601, 0);
    run_txn(2, 0, 45, 300, 4095, 700, 0);
    run_txn(2, 0, 0, 0, 0, 800, 0);
    run_txn(3, 0, 16, 16, 16, 900, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R3 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule